// File: doc/BRIEF.md
# SDRAM Command Bus Monitor

This block watches the command pins of a single-data-rate SDRAM on every rising clock edge and names the command sampled there. It decodes the chip select, the row and column strobes, write enable, the clock enable of this and the previous edge, and the A10 bit into one enumerated command. It keeps an open or closed flag for each bank, and it raises a one-cycle flag for each protocol rule that the command breaks.

It also sits on the data-mask pin and produces two enables. One masks write data in the same cycle. The other marks read data as high impedance, a fixed number of edges after the mask was sampled. A controller bench or an in-system checker places the block on the command bus. It has no path that affects the memory.

All outputs are registered. They show the result for the command sampled at the most recent edge, and they are compared with the bank state held before that edge.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With the previous-edge clock enable high, chip select low and the current clock enable high, the strobes RAS,CAS,WE decode as follows, visible on cmd_o after the sampling edge. 000 gives 1 (mode set), 001 gives 2 (refresh), 011 gives 4 (activate), 101 gives 5 (read), 100 gives 7 (write), 110 gives 9 (burst stop), 010 gives 10 (precharge) and 111 gives 0 (idle). Chip select high gives 0.
- R2: A10 high turns a read into 6 (read with auto precharge), a write into 8 (write with auto precharge) and a precharge into 11 (precharge of all banks). With A10 low, a precharge closes only the bank on ba_i.
- R3: When the clock enable falls, an idle encoding decodes as 12 and sets pd_o, and the refresh encoding decodes as 3 and sets sref_o. While the previous-edge clock enable is low, every command decodes as 0 and changes no bank. pd_o and sref_o clear at the first edge that samples the clock enable high.
- R4: An activate sets that bank's bit in bank_active_o. A single-bank precharge clears that bit, and an all-bank precharge clears every bit.
- R5: An activate of a bank that is already open pulses viol_act_o.
- R6: A mode set, refresh or self-refresh entry while any bank is open pulses viol_idle_o.
- R7: Any non-idle command at the edge right after a mode set pulses viol_mrd_o. From the second edge after the mode set, commands are legal again.
- R8: A read or write with auto precharge holds its bank open for BURST_LEN edges, counting its own edge, and the bank is closed after the last of them. A read or write to that bank inside the window pulses viol_ap_o. Other banks are unaffected.
- R9: wr_mask_o is dqm_i sampled at the same edge, gated by a write data beat. A write command starts BURST_LEN beats at its own edge.
- R10: rd_hiz_o follows dqm_i with RD_DQM_LAT more edges of delay than the write mask. With the default of 2, it is set after the second edge following the edge that sampled dqm_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| a10_i | input | 1 | Auto-precharge / all-bank select bit |
| dqm_i | input | 1 | Data mask pin |
| cmd_o | output | 4 | Decoded command code |
| bank_active_o | output | NUM_BANKS | Open flag for each bank |
| pd_o | output | 1 | Power-down state |
| sref_o | output | 1 | Self-refresh state |
| viol_act_o | output | 1 | Activate of an open bank |
| viol_idle_o | output | 1 | Idle-only command while a bank is open |
| viol_mrd_o | output | 1 | Command too soon after a mode set |
| viol_ap_o | output | 1 | Access to a bank in an auto-precharge burst |
| wr_mask_o | output | 1 | Write data masked this beat |
| rd_hiz_o | output | 1 | Read data driven high impedance |

## Verification
The idle-bank rule and the mode-set spacing rule are checked in separate logic, and both can fire on the same edge. The bench provokes this by opening a bank, issuing a mode set, and issuing a refresh on the very next edge. That refresh breaks both rules, so viol_idle_o and viol_mrd_o must both be high after that edge. The bench then issues an all-bank precharge, after which both flags must be low.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_REF  = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_RDA  = 4'd6,
    CMD_WR   = 4'd7,
    CMD_WRA  = 4'd8,
    CMD_BST  = 4'd9,
    CMD_PRE  = 4'd10,
    CMD_PREA = 4'd11,
    CMD_PDE  = 4'd12
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic     cke_prev_i,
  input  logic     cke_i,
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  input  logic     a10_i,
  output sdr_cmd_e cmd_o
);
  sdr_cmd_e raw;

  always_comb begin
    unique case ({ras_ni, cas_ni, we_ni})
      3'b000:  raw = CMD_MRS;
      3'b001:  raw = CMD_REF;
      3'b011:  raw = CMD_ACT;
      3'b101:  raw = a10_i ? CMD_RDA : CMD_RD;
      3'b100:  raw = a10_i ? CMD_WRA : CMD_WR;
      3'b110:  raw = CMD_BST;
      3'b010:  raw = a10_i ? CMD_PREA : CMD_PRE;
      default: raw = CMD_NOP;
    endcase
    if (cs_ni) raw = CMD_NOP;
  end

  // clock enable low at the previous edge: command is not sampled
  always_comb begin
    if (!cke_prev_i)                cmd_o = CMD_NOP;
    else if (!cke_i && raw == CMD_NOP) cmd_o = CMD_PDE;
    else if (!cke_i && raw == CMD_REF) cmd_o = CMD_SREF;
    else                            cmd_o = raw;
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W   = $clog2(BURST_LEN) + 1,
  localparam int AP_LOAD = BURST_LEN - 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sdr_cmd_e cmd_i,
  input  logic     hit_i,
  output logic     active_o,
  output logic     ap_busy_o
);
  logic [CNT_W-1:0] ap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      ap_cnt   <= '0;
    end else begin
      if (ap_cnt != '0) begin
        ap_cnt <= ap_cnt - CNT_W'(1);
        if (ap_cnt == CNT_W'(1)) active_o <= 1'b0;
      end
      if (hit_i && cmd_i == CMD_ACT) active_o <= 1'b1;
      if (hit_i && (cmd_i == CMD_RDA || cmd_i == CMD_WRA)) begin
        if (AP_LOAD == 0) active_o <= 1'b0;
        else              ap_cnt   <= CNT_W'(AP_LOAD);
      end
      if (cmd_i == CMD_PREA || (hit_i && cmd_i == CMD_PRE)) begin
        active_o <= 1'b0;
        ap_cnt   <= '0;
      end
    end
  end

  assign ap_busy_o = (ap_cnt != '0);

  p_act_opens_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && cmd_i == CMD_ACT) |=> active_o);
  p_prea_closes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PREA) |=> (!active_o && !ap_busy_o));
endmodule

// File: rtl/sdr_dqm_pipe.sv
module sdr_dqm_pipe
  import sdr_mon_pkg::*;
#(
  parameter int BURST_LEN  = 4,
  parameter int RD_DQM_LAT = 2,
  localparam int BEAT_W    = $clog2(BURST_LEN) + 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sdr_cmd_e cmd_i,
  input  logic     dqm_i,
  output logic     wr_mask_o,
  output logic     rd_hiz_o
);
  logic [BEAT_W-1:0]   wr_left;
  logic [RD_DQM_LAT:0] rd_sh;
  logic                wr_cmd, wr_beat;

  assign wr_cmd  = (cmd_i == CMD_WR || cmd_i == CMD_WRA);
  assign wr_beat = wr_cmd || (wr_left != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_left   <= '0;
      wr_mask_o <= 1'b0;
      rd_sh     <= '0;
    end else begin
      wr_mask_o <= wr_beat && dqm_i;
      rd_sh     <= {rd_sh[RD_DQM_LAT-1:0], dqm_i};
      if (wr_cmd)
        wr_left <= BEAT_W'(BURST_LEN - 1);
      else if (cmd_i inside {CMD_RD, CMD_RDA, CMD_BST, CMD_PRE, CMD_PREA})
        wr_left <= '0;
      else if (wr_left != '0)
        wr_left <= wr_left - BEAT_W'(1);
    end
  end

  assign rd_hiz_o = rd_sh[RD_DQM_LAT];

  p_wr_mask_same_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_o |-> $past(dqm_i));
  p_rd_hiz_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hiz_o |-> $past(dqm_i, RD_DQM_LAT + 1));
endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BURST_LEN  = 4,
  parameter int MRS_GAP    = 2,
  parameter int RD_DQM_LAT = 2,
  localparam int BA_W      = $clog2(NUM_BANKS),
  localparam int GAP_W     = $clog2(MRS_GAP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic                 dqm_i,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic                 pd_o,
  output logic                 sref_o,
  output logic                 viol_act_o,
  output logic                 viol_idle_o,
  output logic                 viol_mrd_o,
  output logic                 viol_ap_o,
  output logic                 wr_mask_o,
  output logic                 rd_hiz_o
);
  logic                 cke_prev;
  sdr_cmd_e             cmd;
  logic [NUM_BANKS-1:0] ap_busy;
  logic [GAP_W-1:0]     gap_cnt;
  logic                 is_rw;

  sdr_cmd_decode u_decode (
    .cke_prev_i (cke_prev),
    .cke_i      (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .a10_i      (a10_i),
    .cmd_o      (cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdr_bank_track #(.BURST_LEN(BURST_LEN)) u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (cmd),
      .hit_i     (ba_i == BA_W'(b)),
      .active_o  (bank_active_o[b]),
      .ap_busy_o (ap_busy[b])
    );
  end

  sdr_dqm_pipe #(.BURST_LEN(BURST_LEN), .RD_DQM_LAT(RD_DQM_LAT)) u_dqm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .dqm_i     (dqm_i),
    .wr_mask_o (wr_mask_o),
    .rd_hiz_o  (rd_hiz_o)
  );

  assign is_rw = cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_prev    <= 1'b1;
      cmd_o       <= '0;
      pd_o        <= 1'b0;
      sref_o      <= 1'b0;
      gap_cnt     <= '0;
      viol_act_o  <= 1'b0;
      viol_idle_o <= 1'b0;
      viol_mrd_o  <= 1'b0;
      viol_ap_o   <= 1'b0;
    end else begin
      cke_prev    <= cke_i;
      cmd_o       <= cmd;
      viol_act_o  <= (cmd == CMD_ACT) && bank_active_o[ba_i];
      viol_idle_o <= (cmd inside {CMD_MRS, CMD_REF, CMD_SREF}) && (|bank_active_o);
      viol_mrd_o  <= (cmd != CMD_NOP) && (gap_cnt != '0);
      viol_ap_o   <= is_rw && ap_busy[ba_i];
      if (cmd == CMD_MRS)      gap_cnt <= GAP_W'(MRS_GAP - 1);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - GAP_W'(1);
      if (cke_i) begin
        pd_o   <= 1'b0;
        sref_o <= 1'b0;
      end else if (cmd == CMD_PDE) begin
        pd_o   <= 1'b1;
      end else if (cmd == CMD_SREF) begin
        sref_o <= 1'b1;
      end
    end
  end

  p_act_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_act_o |-> (cmd_o == CMD_ACT));
  p_idle_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_idle_o |-> (cmd_o inside {CMD_MRS, CMD_REF, CMD_SREF}));
  p_mrd_after_mrs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_mrd_o |-> ($past(cmd_o) == CMD_MRS));
  p_ap_on_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_ap_o |-> (cmd_o inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA}));
  p_lowpower_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_o && sref_o));
endmodule

// File: tb/sdr_cmd_monitor_bench.sv
module sdr_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011,
                         P_RD  = 3'b101, P_WR  = 3'b100, P_BST = 3'b110,
                         P_PRE = 3'b010, P_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0, dqm = 1'b0;
  logic [3:0] cmd;
  logic [3:0] act;
  logic pd, sref, v_act, v_idle, v_mrd, v_ap, wmask, rhiz;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_monitor u_sdr_cmd_monitor (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .dqm_i(dqm),
    .cmd_o(cmd), .bank_active_o(act), .pd_o(pd), .sref_o(sref),
    .viol_act_o(v_act), .viol_idle_o(v_idle), .viol_mrd_o(v_mrd),
    .viol_ap_o(v_ap), .wr_mask_o(wmask), .rd_hiz_o(rhiz)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive pins, let one edge sample them, return at the following negedge
  task automatic step(input logic [2:0] p, input logic cs, input logic [1:0] b,
                      input logic a, input logic ck, input logic m);
    {ras_n, cas_n, we_n} = p;
    cs_n = cs; ba = b; a10 = a; cke = ck; dqm = m;
    @(negedge clk);
  endtask

  task automatic nop(input logic m = 1'b0);
    step(P_NOP, 1'b0, 2'd0, 1'b0, 1'b1, m);
  endtask

  task automatic t_reset;
    chk("R1 reset cmd", cmd, 0);
    chk("R4 reset banks", act, 0);
    chk("R5 reset flags", {v_act, v_idle, v_mrd, v_ap, pd, sref, wmask, rhiz}, 0);
  endtask

  task automatic t_decode;
    nop();                              chk("R1 nop", cmd, 0);
    step(P_MRS, 1, 0, 0, 1, 0);         chk("R1 deselect", cmd, 0);
    step(P_ACT, 0, 0, 0, 1, 0);         chk("R1 act", cmd, 4);
    step(P_RD,  0, 0, 0, 1, 0);         chk("R1 read", cmd, 5);
    step(P_WR,  0, 3, 0, 1, 0);         chk("R1 write", cmd, 7);
    step(P_BST, 0, 0, 0, 1, 0);         chk("R1 bst", cmd, 9);
    step(P_PRE, 0, 0, 0, 1, 0);         chk("R1 pre", cmd, 10);
    chk("R2 single pre closes", act, 0);
    step(P_ACT, 0, 2, 0, 1, 0);
    step(P_RD,  0, 2, 1, 1, 0);         chk("R2 read ap", cmd, 6);
    step(P_WR,  0, 3, 1, 1, 0);         chk("R2 write ap", cmd, 8);
    step(P_PRE, 0, 0, 1, 1, 0);         chk("R2 pre all", cmd, 11);
    step(P_REF, 0, 0, 0, 1, 0);         chk("R1 refresh", cmd, 2);
    step(P_MRS, 0, 0, 0, 1, 0);         chk("R1 mode set", cmd, 1);
    nop(); nop();
  endtask

  task automatic t_banks;
    step(P_ACT, 0, 2, 0, 1, 0);
    chk("R4 act b2", act, 4); chk("R5 first act", v_act, 0);
    step(P_ACT, 0, 2, 0, 1, 0);         chk("R5 act open", v_act, 1);
    nop();                              chk("R5 pulse ends", v_act, 0);
    step(P_PRE, 0, 2, 0, 1, 0);         chk("R4 pre b2", act, 0);
    step(P_ACT, 0, 1, 0, 1, 0);
    step(P_ACT, 0, 3, 0, 1, 0);         chk("R4 two banks", act, 10);
    step(P_PRE, 0, 0, 1, 1, 0);         chk("R4 pre all", act, 0);
  endtask

  // idle-rule and mode-set spacing fire on the same edge
  task automatic t_idle_mrd;
    step(P_ACT, 0, 0, 0, 1, 0);
    step(P_REF, 0, 0, 0, 1, 0);         chk("R6 ref open", v_idle, 1);
    nop();                              chk("R6 pulse ends", v_idle, 0);
    step(P_MRS, 0, 0, 0, 1, 0);         chk("R6 mrs open", v_idle, 1);
    chk("R7 mrs itself", v_mrd, 0);
    step(P_REF, 0, 0, 0, 1, 0);
    chk("R6 overlap idle", v_idle, 1);  chk("R7 overlap gap", v_mrd, 1);
    step(P_PRE, 0, 0, 1, 1, 0);
    chk("R7 second edge legal", v_mrd, 0); chk("R6 prea legal", v_idle, 0);
    step(P_REF, 0, 0, 0, 1, 0);         chk("R6 ref idle", v_idle, 0);
    step(P_MRS, 0, 0, 0, 1, 0);
    nop();                              chk("R7 nop in gap", v_mrd, 0);
    step(P_ACT, 0, 0, 0, 1, 0);         chk("R7 act after gap", v_mrd, 0);
    step(P_PRE, 0, 0, 1, 1, 0);
  endtask

  task automatic t_autopre;
    step(P_ACT, 0, 1, 0, 1, 0);
    step(P_RD,  0, 1, 1, 1, 0);         chk("R8 open at ap cmd", act[1], 1);
    step(P_RD,  0, 0, 0, 1, 0);         chk("R8 other bank", v_ap, 0);
    step(P_RD,  0, 1, 0, 1, 0);         chk("R8 access in window", v_ap, 1);
    chk("R8 still open", act[1], 1);
    nop();                              chk("R8 closed at end", act[1], 0);
    step(P_ACT, 0, 1, 0, 1, 0);         chk("R8 reopen legal", v_act, 0);
    step(P_PRE, 0, 0, 1, 1, 0);
  endtask

  task automatic t_lowpower;
    step(P_NOP, 0, 0, 0, 0, 0);
    chk("R3 pde code", cmd, 12);        chk("R3 pd set", pd, 1);
    step(P_ACT, 0, 1, 0, 0, 0);
    chk("R3 ignored cmd", cmd, 0);      chk("R3 no bank", act, 0);
    chk("R3 pd held", pd, 1);
    step(P_NOP, 0, 0, 0, 1, 0);         chk("R3 pd exit", pd, 0);
    nop();
    step(P_REF, 0, 0, 0, 0, 0);
    chk("R3 sref code", cmd, 3);        chk("R3 sref set", sref, 1);
    step(P_NOP, 0, 0, 0, 0, 0);         chk("R3 sref held", sref, 1);
    step(P_NOP, 0, 0, 0, 1, 0);         chk("R3 sref exit", sref, 0);
    nop();
  endtask

  task automatic t_dqm;
    step(P_WR, 0, 0, 0, 1, 1);          chk("R9 mask on write edge", wmask, 1);
    nop(1'b0);                          chk("R9 beat unmasked", wmask, 0);
    nop(1'b1);                          chk("R9 beat three", wmask, 1);
    nop(1'b0);
    nop(1'b1);                          chk("R9 after burst", wmask, 0);
    nop(1'b0); nop(1'b0); nop(1'b0);
    nop(1'b1);                          chk("R10 not yet", rhiz, 0);
    nop(1'b0);                          chk("R10 one edge", rhiz, 0);
    nop(1'b0);                          chk("R10 two edges", rhiz, 1);
    nop(1'b0);                          chk("R10 clears", rhiz, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_decode;
    t_banks;
    t_idle_mrd;
    t_autopre;
    t_lowpower;
    t_dqm;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule